// File: doc/BRIEF.md
# Counter Capture and Threshold Output Unit

This unit sits next to a free-running or gated counter and gives a host two views of it. A rising edge on an external capture pin freezes the current count into a holding register. A sticky "fresh value" flag tells the host that a capture has happened since it last acknowledged one. The host acknowledges by raising its read-select bit. That bit also switches the read-data port from the live count to the held value.

The same unit drives one digital output from an unsigned comparison between the live count and a programmable threshold. There are three behaviours. In the first the output ignores the counter and copies a host-controlled level. In the second it is high while the count is at or above the threshold. In the third it is high while the count is at or below it. The host control word and the host status word are represented at the ports only by the bits this unit uses: read-select is bit 8 of the control word, the standard output level is bit 0 of the control word, and the fresh-value flag is bit 15 of the status word. Counting itself happens elsewhere; the unit only observes `count_val` and the `count_run` qualifier.

Top module: `cnt_latch_cmp`

## Requirements
- R1: A rising edge on `cap_pin` is captured after two synchronising flops. If `cap_pin` is first sampled high at clock edge k after being low at edge k-1, and `count_run` is 1 at edge k+2, the held value takes the `count_val` present at edge k+2.
- R2: When `count_run` is 0 at the edge where a synchronised rising edge is acted upon, the held value and `stat_new` are unchanged.
- R3: Every capture sets `stat_new` (status word bit 15) to 1, starting in the cycle after the capture edge.
- R4: `rd_data` equals the held value while `ctrl_rdsel` (control word bit 8) is 1, and equals `count_val` while it is 0. The selection is combinational with no clock delay.
- R5: `stat_new` is cleared only at a clock edge where `ctrl_rdsel` is 1 and was 0 at the previous edge. Holding `ctrl_rdsel` at 1 does not clear a flag set by a later capture.
- R6: When a capture and a rising edge of `ctrl_rdsel` fall on the same clock edge, the capture wins and `stat_new` is 1 afterwards.
- R7: With `out_mode` = 2'b00 (or the unused code 2'b11), `out_pin` follows `ctrl_stdout` (control word bit 0).
- R8: With `out_mode` = 2'b01, `out_pin` is 1 exactly when `count_val` >= `cmp_val`, compared unsigned.
- R9: With `out_mode` = 2'b10, `out_pin` is 1 exactly when `count_val` <= `cmp_val`, compared unsigned.
- R10: `out_pin` is registered. It shows, after clock edge k, the result computed from the inputs present at edge k.
- R11: A clock edge with `rst_n` low clears the held value, `stat_new`, `out_pin` and the synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_val | input | CNT_W | Live count from the counter |
| count_run | input | 1 | High while counting is active; enables capture |
| cap_pin | input | 1 | Asynchronous capture pin |
| ctrl_rdsel | input | 1 | Control word bit 8: select held value and acknowledge |
| ctrl_stdout | input | 1 | Control word bit 0: level used in the "never" mode |
| cmp_val | input | CNT_W | Comparison threshold |
| out_mode | input | 2 | 00 never, 01 at-or-above, 10 at-or-below, 11 as 00 |
| rd_data | output | CNT_W | Live count or held value |
| stat_new | output | 1 | Status word bit 15: fresh captured value present |
| out_pin | output | 1 | Registered threshold output |

## Verification
A corrupted held value shows on `rd_data` in the very cycle the host selects it. A flag that fails to set, or is cleared by a held select, shows on `stat_new` one cycle after the responsible edge. An off-by-one in the synchroniser shows as a captured count that belongs to the neighbouring cycle. The count is changed on every cycle, so that error is visible. A wrong comparison direction or an equality slip shows on `out_pin` one cycle later. To make that visible, thresholds and counts are drawn from a narrow range so that equality occurs often.

// File: rtl/clm_pkg.sv
// Package: shared encodings for the counter capture and threshold unit.
// Assumes: out_mode is two bits; code 2'b11 behaves as the "never" mode.
package clm_pkg;
    typedef enum logic [1:0] {
        OM_FIXED = 2'b00,
        OM_AT_OR_ABOVE = 2'b01,
        OM_AT_OR_BELOW = 2'b10,
        OM_SPARE = 2'b11
    } out_mode_e;
endpackage

// File: rtl/clm_edge_sync.sv
// Module: brings an asynchronous pin into the clock domain through STAGES
// flops and flags one-cycle rising edges of the synchronised level.
// Assumes: STAGES >= 2; synchronous active-low reset clears all flops.
module clm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic rise_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] sync_q;
    logic          prev_q;

    // Shift the pin through the synchroniser chain and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[LAST-1:0], pin_in};
            prev_q <= sync_q[LAST];
        end
    end

    assign rise_o = sync_q[LAST] & ~prev_q;

    // R1: an edge seen at the chain output was present on the pin two edges earlier
    p_sync_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o && STAGES == 2) |-> $past(pin_in, 2));

    // R1: a detected edge lasts exactly one cycle
    p_rise_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/clm_capture.sv
// Module: holding register for captured counts, sticky fresh-value flag
// with read-select acknowledge, and the read-data selector.
// Assumes: cap_evt is a single-cycle pulse; acknowledge is the rising edge
// of rdsel; a capture takes priority over an acknowledge on the same edge.
module clm_capture #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_evt,
    input  logic             run,
    input  logic [CNT_W-1:0] count_val,
    input  logic             rdsel,
    output logic [CNT_W-1:0] rd_data,
    output logic             flag_o
);
    logic [CNT_W-1:0] held_q;
    logic             flag_q;
    logic             rdsel_q;
    logic             take;
    logic             ack;

    assign take = cap_evt & run;
    assign ack  = rdsel & ~rdsel_q;

    // Load the holding register on a qualified capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (take) begin
            held_q <= count_val;
        end
    end

    // Track the select bit so its rising edge can be recognised.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdsel_q <= 1'b0;
        end else begin
            rdsel_q <= rdsel;
        end
    end

    // Set the flag on capture, clear it on acknowledge, capture winning.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (take) begin
            flag_q <= 1'b1;
        end else if (ack) begin
            flag_q <= 1'b0;
        end
    end

    // Present either the held value or the live count to the host.
    always_comb begin
        if (rdsel) begin
            rd_data = held_q;
        end else begin
            rd_data = count_val;
        end
    end

    assign flag_o = flag_q;

    // R1: a qualified capture stores the count of that edge
    p_hold_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> held_q == $past(count_val));

    // R2: without a qualified capture the held value does not move
    p_hold_still_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(held_q));

    // R3, R6: any capture leaves the flag set, acknowledge or not
    p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> flag_q);

    // R5: a select edge without capture clears the flag
    p_flag_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !take) |=> !flag_q);

    // R5: with neither event the flag keeps its value
    p_flag_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && !take) |=> $stable(flag_q));
endmodule

// File: rtl/clm_compare.sv
// Module: registered threshold output with three behaviours selected by mode.
// Assumes: unsigned comparison; the spare mode code acts as the fixed mode.
module clm_compare #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_val,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [1:0]       mode,
    input  logic             std_lvl,
    output logic             out_o
);
    import clm_pkg::*;

    logic at_or_above;
    logic at_or_below;
    logic next_out;
    logic out_q;

    assign at_or_above = (count_val >= cmp_val);
    assign at_or_below = (count_val <= cmp_val);

    // Choose the next output level from the active behaviour.
    always_comb begin
        case (out_mode_e'(mode))
            OM_AT_OR_ABOVE: next_out = at_or_above;
            OM_AT_OR_BELOW: next_out = at_or_below;
            default:        next_out = std_lvl;
        endcase
    end

    // Register the output level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else begin
            out_q <= next_out;
        end
    end

    assign out_o = out_q;

    // R7: in the fixed or spare mode the output copies the standard level
    p_fixed_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 || mode == 2'b11) |=> out_o == $past(std_lvl));

    // R8: strictly below the threshold the at-or-above output is low
    p_above_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && count_val < cmp_val) |=> !out_o);

    // R9: strictly above the threshold the at-or-below output is low
    p_below_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && count_val > cmp_val) |=> !out_o);

    // R8, R9: on equality both comparing behaviours drive high
    p_equal_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'b01 || mode == 2'b10) && count_val == cmp_val) |=> out_o);
endmodule

// File: rtl/cnt_latch_cmp.sv
// Module: top of the counter capture and threshold unit. Synchronises the
// capture pin, holds captured counts with a fresh-value flag, and drives a
// registered threshold output.
// Assumes: count_val and cmp_val are synchronous to clk; cap_pin may be asynchronous.
module cnt_latch_cmp #(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_val,
    input  logic             count_run,
    input  logic             cap_pin,
    input  logic             ctrl_rdsel,
    input  logic             ctrl_stdout,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [1:0]       out_mode,
    output logic [CNT_W-1:0] rd_data,
    output logic             stat_new,
    output logic             out_pin
);
    logic cap_rise;

    clm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (cap_pin),
        .rise_o (cap_rise)
    );

    clm_capture #(.CNT_W(CNT_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_evt   (cap_rise),
        .run       (count_run),
        .count_val (count_val),
        .rdsel     (ctrl_rdsel),
        .rd_data   (rd_data),
        .flag_o    (stat_new)
    );

    clm_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_val (count_val),
        .cmp_val   (cmp_val),
        .mode      (out_mode),
        .std_lvl   (ctrl_stdout),
        .out_o     (out_pin)
    );

    // R11: the cycle after a reset edge the flag and output are low
    p_reset_clear_r11: assert property (@(posedge clk)
        !rst_n |=> (!stat_new && !out_pin));

    // R4: with select low the live count is presented unchanged
    p_live_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rdsel |-> rd_data == count_val);
endmodule

// File: tb/sim_cnt_latch_cmp.sv
module sim_cnt_latch_cmp;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] count_val;
    logic         count_run;
    logic         cap_pin;
    logic         ctrl_rdsel;
    logic         ctrl_stdout;
    logic [W-1:0] cmp_val;
    logic [1:0]   out_mode;
    logic [W-1:0] rd_data;
    logic         stat_new;
    logic         out_pin;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // bench model state
    logic         m_s1, m_s2, m_s3, m_ack, m_flag, m_out;
    logic [W-1:0] m_held;

    always #5 clk = ~clk;

    cnt_latch_cmp #(.CNT_W(W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .count_val(count_val), .count_run(count_run),
        .cap_pin(cap_pin), .ctrl_rdsel(ctrl_rdsel), .ctrl_stdout(ctrl_stdout),
        .cmp_val(cmp_val), .out_mode(out_mode), .rd_data(rd_data),
        .stat_new(stat_new), .out_pin(out_pin)
    );

    function automatic logic exp_out(logic [1:0] md, logic [W-1:0] c,
                                     logic [W-1:0] t, logic s);
        case (md)
            2'b01:   return c >= t;
            2'b10:   return c <= t;
            default: return s;
        endcase
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // advance one clock with current inputs, updating the model at the edge
    task automatic step();
        logic take;
        @(posedge clk);
        if (!rst_n) begin
            {m_s1, m_s2, m_s3, m_ack, m_flag, m_out} = '0;
            m_held = '0;
        end else begin
            take = m_s2 & ~m_s3 & count_run;
            if (take) begin
                m_held = count_val;
                m_flag = 1'b1;
            end else if (ctrl_rdsel && !m_ack) begin
                m_flag = 1'b0;
            end
            m_ack = ctrl_rdsel;
            m_s3 = m_s2;
            m_s2 = m_s1;
            m_s1 = cap_pin;
            m_out = exp_out(out_mode, count_val, cmp_val, ctrl_stdout);
        end
        @(negedge clk);
    endtask

    task automatic compare_all();
        check("R4 rd_data", rd_data, ctrl_rdsel ? m_held : count_val);
        check("R3 R5 R6 stat_new", W'(stat_new), W'(m_flag));
        check("R7 R8 R9 R10 out_pin", W'(out_pin), W'(m_out));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; count_val = 32'h55; count_run = 1'b1; cap_pin = 1'b1;
        ctrl_rdsel = 1'b0; ctrl_stdout = 1'b1; cmp_val = '0; out_mode = 2'b00;
        @(negedge clk);
        repeat (3) step();
        // R11: reset state
        check("R11 stat_new", W'(stat_new), '0);
        check("R11 out_pin", W'(out_pin), '0);
        ctrl_rdsel = 1'b1;
        #1;
        check("R11 held value", rd_data, '0);
        ctrl_rdsel = 1'b0;
        cap_pin = 1'b0;
        rst_n = 1'b1;
        step(); step(); step();

        // R1: directed capture latency, count changes every cycle
        for (int i = 0; i < 6; i++) begin
            count_val = 32'h100 + i;
            cap_pin = (i >= 1);
            step();
        end
        ctrl_rdsel = 1'b1;
        #1;
        check("R1 captured count", rd_data, 32'h103);
        check("R3 flag set", W'(stat_new), 1);
        step();
        check("R5 flag cleared by select edge", W'(stat_new), 0);

        // R5: held select does not clear a later capture
        cap_pin = 1'b0; step(); step(); step();
        count_val = 32'h200; cap_pin = 1'b1; step();
        count_val = 32'h201; step();
        count_val = 32'h202; step();
        count_val = 32'h203; step();
        check("R5 later capture survives held select", W'(stat_new), 1);
        check("R1 R4 held value while selected", rd_data, 32'h202);

        // R6: capture and select edge on the same edge
        ctrl_rdsel = 1'b0; cap_pin = 1'b0; step(); step(); step();
        count_val = 32'h300; cap_pin = 1'b1; step();
        count_val = 32'h301; step();
        count_val = 32'h302; ctrl_rdsel = 1'b1; step();
        check("R6 capture wins over acknowledge", W'(stat_new), 1);
        check("R6 captured value", rd_data, 32'h302);

        // R2: no capture while counting inactive
        ctrl_rdsel = 1'b0; cap_pin = 1'b0; step(); step(); step();
        count_run = 1'b0;
        count_val = 32'h400; cap_pin = 1'b1; step(); step(); step(); step();
        check("R2 flag unchanged", W'(stat_new), 1);
        ctrl_rdsel = 1'b1;
        #1;
        check("R2 held value unchanged", rd_data, 32'h302);
        count_run = 1'b1;
        step();

        // R8 R9 R7 R10: directed equality and spare mode
        count_val = 32'd7; cmp_val = 32'd7; out_mode = 2'b01; step();
        check("R8 equal at-or-above", W'(out_pin), 1);
        out_mode = 2'b10; step();
        check("R9 equal at-or-below", W'(out_pin), 1);
        count_val = 32'd8; #1;
        check("R10 output waits for edge", W'(out_pin), 1);
        step();
        check("R9 above threshold", W'(out_pin), 0);
        out_mode = 2'b11; ctrl_stdout = 1'b1; step();
        check("R7 spare mode follows standard level", W'(out_pin), 1);
        out_mode = 2'b00; ctrl_stdout = 1'b0; step();
        check("R7 fixed mode follows standard level", W'(out_pin), 0);

        // random phase: model-based comparison every cycle
        for (int i = 0; i < 4000; i++) begin
            count_val   = $urandom % 16;
            cmp_val     = $urandom % 16;
            if (($urandom % 4) == 0) cap_pin = ~cap_pin;
            count_run   = ($urandom % 8) != 0;
            if (($urandom % 5) == 0) ctrl_rdsel = ~ctrl_rdsel;
            ctrl_stdout = $urandom;
            if (($urandom % 50) == 0) out_mode = $urandom;
            step();
            compare_all();
        end
        finish_run();
    end
endmodule